// File: doc/BRIEF.md
# Bad-Block Skipping Image Loader Sequencer

This block copies a boot image of a given byte length out of a paged flash device into memory. Software or a boot ROM gives it a starting byte offset in flash, the image size in bytes and a destination base address, then pulses start. The sequencer walks the flash one erase block (64 pages of 2048 bytes) at a time. For each page it emits the flash command and address byte sequence, hands the page to an external page reader together with the memory address that page should land at, and waits for the reader to report success or failure and the first two spare-area bytes of that page.

When a block has been walked, the sequencer decides its fate. A block that holds a page whose spare bytes carry a bad marker, or in which no page could be read at all, is skipped: the destination stays where it was and the same part of the image is tried again in the next block, 64 pages further on. A block that is otherwise good but had a failed page read aborts the load with a sticky error. A good block is committed: the destination and the remaining byte, page and block counts move on. The load ends with a one-cycle done pulse once no blocks remain.

Top module: `img_fetch_seq`

## Requirements
- R1: On start, the load covers ceil(size/2048) pages and ceil(size/131072) blocks; a size of 0 produces the done pulse with no page read and no commit.
- R2: The first page read is page offset/2048 (offset bits below 2048 are dropped); page reads are issued one at a time with rd_req_o, and no new command byte or request appears until rd_done_i has answered the previous request.
- R3: Before each rd_req_o, exactly seven bytes appear on nf_byte_o with nf_valid_o high: 0x00 with nf_cmd_o=1, two 0x00 with nf_addr_o=1, the three page-address bytes least significant first with nf_addr_o=1, then 0x30 with nf_cmd_o=1; rd_req_o follows in the cycle after the last byte.
- R4: A read with rd_ok_i=1 and rd_spare0_i or rd_spare1_i different from 0xFF marks its block bad, and no further page of that block is read; spare bytes of a failed read (rd_ok_i=0) are ignored.
- R5: A block in which every page read failed is treated as bad and skipped without raising an error.
- R6: A block with at least one failed read, at least one successful read and no bad marker ends the load: err_o goes to 1 with no commit and no done pulse, and stays 1 until the next start, which clears it.
- R7: A skipped block produces no commit, leaves the destination address unchanged, and the next block starts 64 pages after the start of the skipped one.
- R8: A good block reads min(pages remaining, 64) pages and produces one commit_o pulse with commit_bytes_o = min(bytes remaining, 131072); the destination then advances by that amount, so a final block may be partial.
- R9: busy_o is 1 from the cycle after an accepted start until the load ends; done_o is a single-cycle pulse, raised only on a successful end, never together with err_o.
- R10: rd_dst_o equals the current destination address plus 2048 times the page's index within its block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a load (accepted only when idle) |
| offset_i | input | SZW | Flash byte offset of the image |
| size_i | input | SZW | Image size in bytes |
| dst_base_i | input | AW | Memory address of the first image byte |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse: load completed |
| err_o | output | 1 | Sticky: load aborted on a read error in a good block |
| nf_valid_o | output | 1 | A flash command or address byte is presented |
| nf_cmd_o | output | 1 | Presented byte is a command |
| nf_addr_o | output | 1 | Presented byte is an address byte |
| nf_byte_o | output | 8 | Command or address byte |
| rd_req_o | output | 1 | One-cycle request to the page reader |
| rd_page_o | output | PGW | Flash page number of the current read |
| rd_dst_o | output | AW | Memory address for the current page |
| rd_done_i | input | 1 | Page reader finished (one cycle) |
| rd_ok_i | input | 1 | Page read succeeded, valid with rd_done_i |
| rd_spare0_i | input | 8 | First spare byte of the page, valid with rd_done_i |
| rd_spare1_i | input | 8 | Second spare byte of the page, valid with rd_done_i |
| commit_o | output | 1 | One-cycle pulse: current block accepted |
| commit_bytes_o | output | SZW | Bytes accepted by the commit |

## Verification
The loader is tried with an empty image, a short image starting at a block-aligned offset, an image of exactly one block and one of one block plus a byte, which separate the rounding of page and block counts and the partial final commit. A long image runs over a block marked bad partway through (marker in the second spare byte, after an earlier failed read in that block) and a block where every read fails, which tells the skip rules apart from the fatal rule and shows that skipping does not move the destination. An image whose second page fails with zero spare bytes must end in error, which exposes a design that treats the spare bytes of a failed read as a marker, and a following load from an unaligned offset whose first page carries a marker in the first spare byte shows that start clears the error and that a block stops at its first marked page.

// File: rtl/img_fetch_pkg.sv
package img_fetch_pkg;

   // Sequencer states of the loader
   typedef enum logic [2:0] {
      S_IDLE,   // waiting for start
      S_CHK,    // block boundary: finish or set up the next block
      S_ISSUE,  // kick the command emitter
      S_CMD,    // command and address bytes on the flash bus
      S_REQ,    // request the page transfer
      S_WAIT,   // wait for the page reader
      S_VERD    // classify the block just walked
   } fsm_t;

endpackage

// File: rtl/img_cmd_emit.sv
module img_cmd_emit #(
   parameter int          PGW       = 24,
   parameter int          COL_BYTES = 2,
   parameter logic [7:0]  CMD_READ  = 8'h00,
   parameter logic [7:0]  CMD_START = 8'h30
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go_i,
   input  logic [PGW-1:0] page_i,
   output logic           bvalid_o,
   output logic           bcmd_o,
   output logic           baddr_o,
   output logic [7:0]     bdata_o,
   output logic           fin_o
);
   localparam int ADDR_BYTES = PGW / 8;
   localparam int SEQ_LEN    = 2 + COL_BYTES + ADDR_BYTES;
   localparam int IXW        = $clog2(SEQ_LEN);
   localparam int NSLOT      = 1 << IXW;
   localparam logic [IXW-1:0] LAST_IX = IXW'(SEQ_LEN - 1);

   if (PGW % 8 != 0) begin : g_chk_pgw
      $error("img_cmd_emit: PGW must be a whole number of bytes");
   end
   if (COL_BYTES < 1) begin : g_chk_col
      $error("img_cmd_emit: at least one column byte is needed");
   end

   logic           act_q;
   logic [IXW-1:0] idx_q;
   logic [PGW-1:0] page_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         idx_q  <= '0;
         page_q <= '0;
      end else if (go_i) begin
         act_q  <= 1'b1;
         idx_q  <= '0;
         page_q <= page_i;
      end else if (act_q) begin
         if (idx_q == LAST_IX) begin
            act_q <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // Byte slots of the sequence, built from the geometry parameters
   logic [7:0] slot_b [NSLOT];
   logic       slot_c [NSLOT];

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (i == 0) begin : g_open
         assign slot_b[i] = CMD_READ;
         assign slot_c[i] = 1'b1;
      end else if (i <= COL_BYTES) begin : g_col
         assign slot_b[i] = 8'h00;
         assign slot_c[i] = 1'b0;
      end else if (i <= COL_BYTES + ADDR_BYTES) begin : g_row
         assign slot_b[i] = page_q[8*(i-1-COL_BYTES) +: 8];
         assign slot_c[i] = 1'b0;
      end else if (i == SEQ_LEN - 1) begin : g_close
         assign slot_b[i] = CMD_START;
         assign slot_c[i] = 1'b1;
      end else begin : g_pad
         assign slot_b[i] = 8'h00;
         assign slot_c[i] = 1'b0;
      end
   end

   assign bvalid_o = act_q;
   assign bdata_o  = act_q ? slot_b[idx_q] : 8'h00;
   assign bcmd_o   = act_q &  slot_c[idx_q];
   assign baddr_o  = act_q & ~slot_c[idx_q];
   assign fin_o    = act_q && (idx_q == LAST_IX);

endmodule

// File: rtl/img_blk_verdict.sv
module img_blk_verdict (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       upd_i,
   input  logic       ok_i,
   input  logic [7:0] sp0_i,
   input  logic [7:0] sp1_i,
   output logic       mark_now_o,
   output logic       blk_bad_o,
   output logic       fatal_o
);
   logic good_q;
   logic fail_q;
   logic mark_q;

   // Spare bytes only count when the read itself succeeded
   assign mark_now_o = ok_i && ((sp0_i != 8'hFF) || (sp1_i != 8'hFF));

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         good_q <= 1'b0;
         fail_q <= 1'b0;
         mark_q <= 1'b0;
      end else if (upd_i) begin
         if (ok_i) begin
            good_q <= 1'b1;
         end else begin
            fail_q <= 1'b1;
         end
         if (mark_now_o) begin
            mark_q <= 1'b1;
         end
      end
   end

   assign blk_bad_o = mark_q | ~good_q;
   assign fatal_o   = fail_q & good_q & ~mark_q;

endmodule

// File: rtl/img_load_ledger.sv
module img_load_ledger #(
   parameter int AW         = 32,
   parameter int SZW        = 32,
   parameter int PAGE_BYTES = 2048,
   parameter int BLK_PAGES  = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_i,
   input  logic [SZW-1:0]                 size_i,
   input  logic [AW-1:0]                  base_i,
   input  logic                           commit_i,
   output logic [AW-1:0]                  dst_o,
   output logic [$clog2(BLK_PAGES):0]     blk_pages_o,
   output logic [SZW-1:0]                 commit_bytes_o,
   output logic                           none_left_o
);
   localparam int PG_SH     = $clog2(PAGE_BYTES);
   localparam int PPB_SH    = $clog2(BLK_PAGES);
   localparam int BLK_SH    = PG_SH + PPB_SH;
   localparam int BLK_BYTES = PAGE_BYTES * BLK_PAGES;
   localparam int IW        = PPB_SH + 1;
   localparam int PLW       = SZW + 1 - PG_SH;
   localparam int BLW       = SZW + 1 - BLK_SH;

   logic [AW-1:0]  dst_q;
   logic [SZW-1:0] bytes_q;
   logic [PLW-1:0] pages_q;
   logic [BLW-1:0] blocks_q;

   logic [SZW:0]   size_x;
   logic [PLW-1:0] pg_ceil;
   logic [BLW-1:0] bk_ceil;

   assign size_x  = {1'b0, size_i};
   assign pg_ceil = PLW'((size_x + (SZW+1)'(PAGE_BYTES - 1)) >> PG_SH);
   assign bk_ceil = BLW'((size_x + (SZW+1)'(BLK_BYTES - 1)) >> BLK_SH);

   assign commit_bytes_o = (bytes_q < SZW'(BLK_BYTES)) ? bytes_q : SZW'(BLK_BYTES);
   assign blk_pages_o    = (pages_q < PLW'(BLK_PAGES)) ? IW'(pages_q) : IW'(BLK_PAGES);
   assign none_left_o    = (blocks_q == '0);
   assign dst_o          = dst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_q    <= '0;
         bytes_q  <= '0;
         pages_q  <= '0;
         blocks_q <= '0;
      end else if (load_i) begin
         dst_q    <= base_i;
         bytes_q  <= size_i;
         pages_q  <= pg_ceil;
         blocks_q <= bk_ceil;
      end else if (commit_i) begin
         dst_q    <= dst_q + AW'(commit_bytes_o);
         bytes_q  <= bytes_q - commit_bytes_o;
         pages_q  <= pages_q - PLW'(blk_pages_o);
         blocks_q <= blocks_q - 1'b1;
      end
   end

endmodule

// File: rtl/img_fetch_seq.sv
module img_fetch_seq
   import img_fetch_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          SZW        = 32,
   parameter int          PGW        = 24,
   parameter int          PAGE_BYTES = 2048,
   parameter int          BLK_PAGES  = 64,
   parameter int          COL_BYTES  = 2,
   parameter logic [7:0]  CMD_READ   = 8'h00,
   parameter logic [7:0]  CMD_START  = 8'h30
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [SZW-1:0] offset_i,
   input  logic [SZW-1:0] size_i,
   input  logic [AW-1:0]  dst_base_i,
   output logic           busy_o,
   output logic           done_o,
   output logic           err_o,
   output logic           nf_valid_o,
   output logic           nf_cmd_o,
   output logic           nf_addr_o,
   output logic [7:0]     nf_byte_o,
   output logic           rd_req_o,
   output logic [PGW-1:0] rd_page_o,
   output logic [AW-1:0]  rd_dst_o,
   input  logic           rd_done_i,
   input  logic           rd_ok_i,
   input  logic [7:0]     rd_spare0_i,
   input  logic [7:0]     rd_spare1_i,
   output logic           commit_o,
   output logic [SZW-1:0] commit_bytes_o
);
   localparam int PG_SH  = $clog2(PAGE_BYTES);
   localparam int PPB_SH = $clog2(BLK_PAGES);
   localparam int BLK_SH = PG_SH + PPB_SH;
   localparam int IW     = PPB_SH + 1;

   if ((1 << PG_SH) != PAGE_BYTES) begin : g_chk_page
      $error("img_fetch_seq: PAGE_BYTES must be a power of two");
   end
   if ((1 << PPB_SH) != BLK_PAGES) begin : g_chk_blk
      $error("img_fetch_seq: BLK_PAGES must be a power of two");
   end
   if (SZW <= BLK_SH) begin : g_chk_szw
      $error("img_fetch_seq: SZW must exceed the block size exponent");
   end
   if (PGW % 8 != 0 || PGW < 8) begin : g_chk_pgw
      $error("img_fetch_seq: PGW must be a nonzero whole number of bytes");
   end

   fsm_t           state_q;
   logic [PGW-1:0] blk_base_q;
   logic [IW-1:0]  ptr_q;
   logic           err_q;
   logic           done_q;

   logic           emit_fin;
   logic           mark_now;
   logic           blk_bad;
   logic           fatal;
   logic           ldg_none;
   logic [IW-1:0]  ldg_pages;
   logic [AW-1:0]  ldg_dst;
   logic           last_pg;
   logic           take_blk;
   logic           rd_upd;

   assign rd_page_o = blk_base_q + PGW'(ptr_q);
   assign rd_dst_o  = ldg_dst + (AW'(ptr_q) << PG_SH);
   assign rd_req_o  = (state_q == S_REQ);
   assign rd_upd    = (state_q == S_WAIT) && rd_done_i;
   assign last_pg   = ((ptr_q + 1'b1) == ldg_pages);
   assign take_blk  = (state_q == S_VERD) && !blk_bad && !fatal;
   assign commit_o  = take_blk;

   assign busy_o = (state_q != S_IDLE);
   assign done_o = done_q;
   assign err_o  = err_q;

   img_cmd_emit #(
      .PGW       (PGW),
      .COL_BYTES (COL_BYTES),
      .CMD_READ  (CMD_READ),
      .CMD_START (CMD_START)
   ) u_emit (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (state_q == S_ISSUE),
      .page_i   (rd_page_o),
      .bvalid_o (nf_valid_o),
      .bcmd_o   (nf_cmd_o),
      .baddr_o  (nf_addr_o),
      .bdata_o  (nf_byte_o),
      .fin_o    (emit_fin)
   );

   img_blk_verdict u_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (state_q == S_CHK),
      .upd_i      (rd_upd),
      .ok_i       (rd_ok_i),
      .sp0_i      (rd_spare0_i),
      .sp1_i      (rd_spare1_i),
      .mark_now_o (mark_now),
      .blk_bad_o  (blk_bad),
      .fatal_o    (fatal)
   );

   img_load_ledger #(
      .AW         (AW),
      .SZW        (SZW),
      .PAGE_BYTES (PAGE_BYTES),
      .BLK_PAGES  (BLK_PAGES)
   ) u_ledger (
      .clk            (clk),
      .rst_n          (rst_n),
      .load_i         ((state_q == S_IDLE) && start_i),
      .size_i         (size_i),
      .base_i         (dst_base_i),
      .commit_i       (take_blk),
      .dst_o          (ldg_dst),
      .blk_pages_o    (ldg_pages),
      .commit_bytes_o (commit_bytes_o),
      .none_left_o    (ldg_none)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         blk_base_q <= '0;
         ptr_q      <= '0;
         err_q      <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (start_i) begin
                  err_q      <= 1'b0;
                  blk_base_q <= PGW'(offset_i >> PG_SH);
                  state_q    <= S_CHK;
               end
            end
            S_CHK: begin
               if (ldg_none) begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  ptr_q   <= '0;
                  state_q <= S_ISSUE;
               end
            end
            S_ISSUE: begin
               state_q <= S_CMD;
            end
            S_CMD: begin
               if (emit_fin) begin
                  state_q <= S_REQ;
               end
            end
            S_REQ: begin
               state_q <= S_WAIT;
            end
            S_WAIT: begin
               if (rd_done_i) begin
                  ptr_q <= ptr_q + 1'b1;
                  if (mark_now || last_pg) begin
                     state_q <= S_VERD;
                  end else begin
                     state_q <= S_ISSUE;
                  end
               end
            end
            S_VERD: begin
               if (fatal) begin
                  err_q   <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  blk_base_q <= blk_base_q + PGW'(BLK_PAGES);
                  state_q    <= S_CHK;
               end
            end
            default: begin
               state_q <= S_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/img_fetch_chk.sv
module img_fetch_chk #(
   parameter int          SZW        = 32,
   parameter int          PAGE_BYTES = 2048,
   parameter int          BLK_PAGES  = 64,
   parameter logic [7:0]  CMD_READ   = 8'h00,
   parameter logic [7:0]  CMD_START  = 8'h30
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start_i,
   input logic           busy_o,
   input logic           done_o,
   input logic           err_o,
   input logic           nf_valid_o,
   input logic           nf_cmd_o,
   input logic [7:0]     nf_byte_o,
   input logic           rd_req_o,
   input logic           rd_done_i,
   input logic           commit_o,
   input logic [SZW-1:0] commit_bytes_o
);
   localparam int BLK_BYTES = PAGE_BYTES * BLK_PAGES;

   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (rd_req_o) begin
         pend_q <= 1'b1;
      end else if (rd_done_i) begin
         pend_q <= 1'b0;
      end
   end

   p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> !pend_q);

   p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      nf_valid_o |-> !pend_q);

   p_first_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nf_valid_o) |-> (nf_cmd_o && (nf_byte_o == CMD_READ)));

   p_req_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> $past(nf_valid_o && nf_cmd_o && (nf_byte_o == CMD_START)));

   p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> err_o);

   p_err_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !commit_o);

   p_commit_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> ((commit_bytes_o != '0) && (commit_bytes_o <= SZW'(BLK_BYTES))));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !err_o));

endmodule

bind img_fetch_seq img_fetch_chk #(
   .SZW        (SZW),
   .PAGE_BYTES (PAGE_BYTES),
   .BLK_PAGES  (BLK_PAGES),
   .CMD_READ   (CMD_READ),
   .CMD_START  (CMD_START)
) u_chk (.*);

// File: tb/img_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module img_fetch_seq_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] offset_i = '0;
   logic [31:0] size_i = '0;
   logic [31:0] dst_base_i = '0;
   logic        busy_o, done_o, err_o;
   logic        nf_valid_o, nf_cmd_o, nf_addr_o;
   logic [7:0]  nf_byte_o;
   logic        rd_req_o;
   logic [23:0] rd_page_o;
   logic [31:0] rd_dst_o;
   logic        rd_done_i = 1'b0;
   logic        rd_ok_i = 1'b0;
   logic [7:0]  rd_spare0_i = 8'hFF;
   logic [7:0]  rd_spare1_i = 8'hFF;
   logic        commit_o;
   logic [31:0] commit_bytes_o;

   always #(CLK_P/2) clk = ~clk;

   img_fetch_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
      .size_i(size_i), .dst_base_i(dst_base_i), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o), .nf_valid_o(nf_valid_o),
      .nf_cmd_o(nf_cmd_o), .nf_addr_o(nf_addr_o), .nf_byte_o(nf_byte_o),
      .rd_req_o(rd_req_o), .rd_page_o(rd_page_o), .rd_dst_o(rd_dst_o),
      .rd_done_i(rd_done_i), .rd_ok_i(rd_ok_i), .rd_spare0_i(rd_spare0_i),
      .rd_spare1_i(rd_spare1_i), .commit_o(commit_o),
      .commit_bytes_o(commit_bytes_o)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   int  scen = 0;
   bit  finished = 0;

   longint exp_pg[$];
   longint exp_dst[$];
   longint exp_cm[$];
   bit     exp_err;

   int     done_cnt;
   bit     err_rise;

   task automatic expect_eq(string rq, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // Flash behaviour per scenario
   function automatic bit pg_fail(longint p);
      case (scen)
         4: return ((p >= 128 && p < 192) || p == 66);
         5: return (p == 201);
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit pg_mark(longint p);
      case (scen)
         4: return (p == 69);
         6: return (p == 1);
         default: return 1'b0;
      endcase
   endfunction

   // Behavioural model of the whole load
   task automatic predict(longint off, longint sz, longint base);
      longint pl, bl, byl, pg, dst, cb;
      int     bp, good, errs;
      bit     bad;
      exp_pg.delete(); exp_dst.delete(); exp_cm.delete();
      exp_err = 1'b0;
      pl  = (sz + 2047) / 2048;
      bl  = (sz + 131071) / 131072;
      byl = sz;
      pg  = off / 2048;
      dst = base;
      while (bl > 0) begin
         bp = (pl < 64) ? int'(pl) : 64;
         good = 0; errs = 0; bad = 1'b0;
         for (int k = 0; k < bp && !bad; k++) begin
            exp_pg.push_back(pg + k);
            exp_dst.push_back(dst + k * 2048);
            if (pg_fail(pg + k)) errs++;
            else begin
               good++;
               if (pg_mark(pg + k)) bad = 1'b1;
            end
         end
         if (good == 0) bad = 1'b1;
         if (errs > 0 && !bad) begin
            exp_err = 1'b1;
            return;
         end
         if (!bad) begin
            cb = (byl < 131072) ? byl : 131072;
            exp_cm.push_back(cb);
            dst += cb; byl -= cb; pl -= bp; bl--;
         end
         pg += 64;
      end
   endtask

   // Page reader model: answers each request after 1..3 cycles
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rd_req_o) begin
            longint p;
            p = rd_page_o;
            repeat (int'(p % 3) + 1) @(negedge clk);
            rd_done_i = 1'b1;
            if (pg_fail(p)) begin
               rd_ok_i = 1'b0; rd_spare0_i = 8'h00; rd_spare1_i = 8'h00;
            end else if (pg_mark(p)) begin
               rd_ok_i = 1'b1;
               rd_spare0_i = (scen == 6) ? 8'h7F : 8'hFF;
               rd_spare1_i = (scen == 6) ? 8'hFF : 8'h00;
            end else begin
               rd_ok_i = 1'b1; rd_spare0_i = 8'hFF; rd_spare1_i = 8'hFF;
            end
            @(negedge clk);
            rd_done_i = 1'b0;
            rd_ok_i = 1'b0;
         end
      end
   end

   // Clock-by-clock comparison against the model
   logic [7:0] cb_b [8];
   bit         cb_c [8];
   bit         cb_a [8];
   int         cb_n = 0;
   bit         pend = 0;
   bit         err_prev = 0;

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (nf_valid_o) begin
            if (cb_n < 8) begin
               cb_b[cb_n] = nf_byte_o; cb_c[cb_n] = nf_cmd_o; cb_a[cb_n] = nf_addr_o;
            end
            cb_n++;
         end
         if (rd_done_i) pend = 0;
         if (rd_req_o) begin
            longint ep, ed, av, ev;
            int     af, ef;
            expect_eq("R2", "request while a read is outstanding", longint'(pend), 0);
            pend = 1;
            if (exp_pg.size() == 0) begin
               expect_eq("R2", "unexpected page read", longint'(rd_page_o), -1);
            end else begin
               ep = exp_pg.pop_front();
               ed = exp_dst.pop_front();
               expect_eq("R2", "page number", longint'(rd_page_o), ep);
               expect_eq("R10", "page destination", longint'(rd_dst_o), ed);
               av = 0; ev = 0; af = 0; ef = 0;
               for (int i = 0; i < 7; i++) begin
                  av = (av << 8) | longint'(cb_b[i]);
                  af = (af << 2) | (int'(cb_c[i]) << 1) | int'(cb_a[i]);
               end
               ev = (longint'(8'h00) << 48) | (longint'(ep & 'hFF) << 24) |
                    (longint'((ep >> 8) & 'hFF) << 16) | (longint'((ep >> 16) & 'hFF) << 8) |
                    longint'(8'h30);
               ef = 'b10_01_01_01_01_01_10;
               expect_eq("R3", "command byte count", cb_n, 7);
               expect_eq("R3", "command bytes", av, ev);
               expect_eq("R3", "command/address flags", af, ef);
            end
            cb_n = 0;
         end
         if (commit_o) begin
            if (exp_cm.size() == 0) begin
               expect_eq("R7", "unexpected commit", longint'(commit_bytes_o), -1);
            end else begin
               expect_eq("R8", "commit bytes", longint'(commit_bytes_o), exp_cm.pop_front());
            end
         end
         if (done_o) done_cnt++;
         if (err_o && !err_prev) err_rise = 1;
         err_prev = err_o;
      end
   end

   task automatic run(int s, longint off, longint sz, longint base, string rq);
      scen = s;
      predict(off, sz, base);
      done_cnt = 0;
      err_rise = 0;
      @(negedge clk);
      offset_i = off[31:0]; size_i = sz[31:0]; dst_base_i = base[31:0];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      expect_eq("R6", "error cleared by start", longint'(err_o), 0);
      expect_eq("R9", "busy after start", longint'(busy_o), 1);
      while (!(done_cnt > 0 || err_rise)) @(negedge clk);
      repeat (5) @(negedge clk);
      expect_eq(rq, "end in error", longint'(err_o), longint'(exp_err));
      expect_eq("R9", "done pulses", done_cnt, exp_err ? 0 : 1);
      expect_eq("R9", "idle at end", longint'(busy_o), 0);
      expect_eq(rq, "page reads left over", exp_pg.size(), 0);
      expect_eq(rq, "commits left over", exp_cm.size(), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_eq("R9", "reset busy", longint'(busy_o), 0);
      expect_eq("R9", "reset done", longint'(done_o), 0);
      expect_eq("R6", "reset error", longint'(err_o), 0);
      expect_eq("R2", "reset request", longint'(rd_req_o), 0);
      expect_eq("R3", "reset bus", longint'(nf_valid_o), 0);
      expect_eq("R8", "reset commit", longint'(commit_o), 0);

      run(1, 0, 0, 'h1000, "R1");                          // empty image
      run(2, 'h40000, 5000, 'h8000_0000, "R1 R8");         // three pages from page 128
      run(4, 0, 262244, 'h1000_0000, "R4 R5 R7");          // marked and unreadable blocks
      run(5, 200 * 2048, 4096, 'h2000, "R6");              // failure in a good block
      repeat (3) @(negedge clk);
      expect_eq("R6", "error still held", longint'(err_o), 1);
      run(6, 3000, 2049, 'h3000, "R2 R4 R7");              // unaligned, first page marked
      run(7, 0, 131072, 0, "R1 R8");                       // exactly one block
      run(8, 2048 * 5, 131073, 'h4000, "R1 R8");           // one block plus one byte

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule